// File: doc/BRIEF.md
# String Output Transfer Engine

This engine streams a block of bytes from memory to one I/O port without a processor touching each byte. Software, or an upstream controller, gives it a single start pulse carrying four values: the first memory address, the number of bytes, the destination port address and a direction bit. The engine then loops on its own. In each loop it fetches one byte from memory at the current pointer and waits for that byte to come back. It then writes the byte to the port, moves the pointer one step and reduces the remaining count by one. The loop ends when the count reaches zero.

The memory side has two parts. A read request channel uses a valid/ready handshake, and a response channel carries data back with a valid strobe. The port side is a write channel with its own valid/ready handshake. The port address never changes during a transfer. The direction bit selects whether the pointer climbs or falls. The status outputs are a busy level and a one-cycle done pulse. A start pulse that arrives while a transfer is running has no effect.

Top module: `sout_engine`

## Requirements
- R1: Each byte is moved in three steps. A memory read is requested at the current pointer. The returned byte is then written to the port. A read request stays valid, with its address unchanged, until it is accepted.
- R2: Every port write of a transfer carries the port address that was latched at start. That address does not change while busy is high.
- R3: When the direction bit is 0, the address of each memory read after the first is one more than the address of the read before it.
- R4: When the direction bit is 1, the address of each memory read after the first is one less than the address of the read before it.
- R5: A start with count N (N from 1 to 65535) produces exactly N memory reads and exactly N port writes. A count of 1 moves a single byte.
- R6: A start with count 0 produces no memory read and no port write, leaves busy low, and raises done in the cycle after the start.
- R7: A byte's port write is not offered before that byte's read data has returned. Read request and port write are never valid in the same cycle. A port write that is not yet accepted holds its data.
- R8: Busy rises in the cycle after an accepted nonzero start. It stays high until the cycle after the last port write is accepted. Done is high for exactly that one following cycle, and done is never high while busy is high.
- R9: A start pulse while busy is high has no effect. The running transfer keeps its pointer, count and port, and no extra reads or writes follow.
- R10: A count of 0x1000 moves 4096 bytes to the port, in pointer order.
- R11: The pointer wraps modulo 2^ADDR_W in both directions. Stepping down from 0x0000 gives 0xFFFF, and stepping up from 0xFFFF gives 0x0000.
- R12: During and right after reset, busy, done, read request valid and port write valid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, sampled only while idle |
| start_addr_i | input | ADDR_W | First memory byte address |
| count_i | input | CNT_W | Number of bytes to move |
| port_i | input | PORT_W | Destination I/O port address |
| dir_down_i | input | 1 | 0 = pointer climbs, 1 = pointer falls |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| mrd_valid_o | output | 1 | Memory read request valid |
| mrd_addr_o | output | ADDR_W | Memory read address |
| mrd_ready_i | input | 1 | Memory read request accepted |
| mrsp_valid_i | input | 1 | Memory read data valid |
| mrsp_data_i | input | DATA_W | Memory read data |
| iow_valid_o | output | 1 | Port write valid |
| iow_port_o | output | PORT_W | Port write address |
| iow_data_o | output | DATA_W | Port write data |
| iow_ready_i | input | 1 | Port write accepted |

## Verification
Transfers are run in both directions. The memory returns a byte derived from its address, so a pointer stepping the wrong way or skipping an address shows up as a wrong byte at the port and not only as a wrong request address. The bench compares runs with no back-pressure against runs with random read stalls, response latency and port stalls. This separates sequencing that only works at full speed from sequencing that truly waits on each handshake. Separate runs cover a count of zero, a count of one, pointer wrap at both ends of the address space, a start pulse during a transfer, and a 4096-byte block. These catch off-by-one loop ends, wrap errors and a running transfer being overwritten.

// File: rtl/sout_pkg.sv
package sout_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_PUSH  = 2'd3
    } seq_state_e;

    typedef enum logic {
        WALK_UP   = 1'b0,
        WALK_DOWN = 1'b1
    } walk_dir_e;

    typedef struct packed {
        logic load;
        logic capture;
        logic advance;
    } seq_ctl_t;

    function automatic logic seq_active(seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/sout_seq.sv
module sout_seq
    import sout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       zero_cnt_i,
    input  logic       last_i,
    input  logic       mrd_ready_i,
    input  logic       mrsp_valid_i,
    input  logic       iow_ready_i,
    output seq_state_e state_o,
    output seq_ctl_t   ctl_o,
    output logic       done_o
);

    seq_state_e state_q, state_n;
    logic       done_q, done_n;
    seq_ctl_t   ctl;

    always_comb begin
        state_n = state_q;
        done_n  = 1'b0;
        ctl     = '0;
        case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    if (zero_cnt_i) begin
                        done_n = 1'b1;
                    end else begin
                        ctl.load = 1'b1;
                        state_n  = SEQ_FETCH;
                    end
                end
            end
            SEQ_FETCH: begin
                if (mrd_ready_i) state_n = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (mrsp_valid_i) begin
                    ctl.capture = 1'b1;
                    state_n     = SEQ_PUSH;
                end
            end
            SEQ_PUSH: begin
                if (iow_ready_i) begin
                    ctl.advance = 1'b1;
                    if (last_i) begin
                        state_n = SEQ_IDLE;
                        done_n  = 1'b1;
                    end else begin
                        state_n = SEQ_FETCH;
                    end
                end
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= done_n;
        end
    end

    assign state_o = state_q;
    assign ctl_o   = ctl;
    assign done_o  = done_q;

endmodule

// File: rtl/sout_walk.sv
module sout_walk
    import sout_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [PORT_W-1:0] port_i,
    input  walk_dir_e         dir_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [PORT_W-1:0] port_o,
    output logic              last_o,
    output logic              zero_o
);

    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] ptr_q, ptr_step;
    logic [CNT_W-1:0]  cnt_q;
    logic [PORT_W-1:0] port_q;
    walk_dir_e         dir_q;

    always_comb begin
        if (dir_q == WALK_DOWN) ptr_step = ptr_q - PTR_ONE;
        else                    ptr_step = ptr_q + PTR_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            cnt_q  <= '0;
            port_q <= '0;
            dir_q  <= WALK_UP;
        end else if (ctl_i.load) begin
            ptr_q  <= addr_i;
            cnt_q  <= count_i;
            port_q <= port_i;
            dir_q  <= dir_i;
        end else if (ctl_i.advance) begin
            ptr_q  <= ptr_step;
            cnt_q  <= cnt_q - CNT_ONE;
        end
    end

    assign ptr_o  = ptr_q;
    assign port_o = port_q;
    assign last_o = (cnt_q == CNT_ONE);
    assign zero_o = (count_i == '0);

endmodule

// File: rtl/sout_hold.sv
module sout_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (capture_i) q <= d_i;
    end

    assign q_o = q;

endmodule

// File: rtl/sout_engine.sv
module sout_engine
    import sout_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              dir_down_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mrd_valid_o,
    output logic [ADDR_W-1:0] mrd_addr_o,
    input  logic              mrd_ready_i,
    input  logic              mrsp_valid_i,
    input  logic [DATA_W-1:0] mrsp_data_i,
    output logic              iow_valid_o,
    output logic [PORT_W-1:0] iow_port_o,
    output logic [DATA_W-1:0] iow_data_o,
    input  logic              iow_ready_i
);

    seq_state_e state;
    seq_ctl_t   ctl;
    logic       last, zero_cnt;

    sout_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .zero_cnt_i  (zero_cnt),
        .last_i      (last),
        .mrd_ready_i (mrd_ready_i),
        .mrsp_valid_i(mrsp_valid_i),
        .iow_ready_i (iow_ready_i),
        .state_o     (state),
        .ctl_o       (ctl),
        .done_o      (done_o)
    );

    sout_walk #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .PORT_W(PORT_W)
    ) u_walk (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ctl),
        .addr_i(start_addr_i),
        .count_i(count_i),
        .port_i(port_i),
        .dir_i (walk_dir_e'(dir_down_i)),
        .ptr_o (mrd_addr_o),
        .port_o(iow_port_o),
        .last_o(last),
        .zero_o(zero_cnt)
    );

    sout_hold #(
        .DATA_W(DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .capture_i(ctl.capture),
        .d_i      (mrsp_data_i),
        .q_o      (iow_data_o)
    );

    assign busy_o      = seq_active(state);
    assign mrd_valid_o = (state == SEQ_FETCH);
    assign iow_valid_o = (state == SEQ_PUSH);

endmodule

// File: rtl/sout_engine_chk.sv
module sout_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              mrd_valid_o,
    input logic [ADDR_W-1:0] mrd_addr_o,
    input logic              mrd_ready_i,
    input logic              iow_valid_o,
    input logic [PORT_W-1:0] iow_port_o,
    input logic [DATA_W-1:0] iow_data_o,
    input logic              iow_ready_i
);

    assert_rd_hold_R1: assert property (@(posedge clk) disable iff (rst)
        mrd_valid_o && !mrd_ready_i |=> mrd_valid_o && $stable(mrd_addr_o));

    assert_port_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(iow_port_o));

    assert_one_side_R7: assert property (@(posedge clk) disable iff (rst)
        !(mrd_valid_o && iow_valid_o));

    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        iow_valid_o && !iow_ready_i |=> iow_valid_o && $stable(iow_data_o));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o && !(iow_valid_o && iow_ready_i) |=> busy_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i && !(iow_valid_o && iow_ready_i) |=> busy_o && $stable(iow_port_o));

endmodule

bind sout_engine sout_engine_chk #(
    .ADDR_W(ADDR_W),
    .PORT_W(PORT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mrd_valid_o(mrd_valid_o),
    .mrd_addr_o (mrd_addr_o),
    .mrd_ready_i(mrd_ready_i),
    .iow_valid_o(iow_valid_o),
    .iow_port_o (iow_port_o),
    .iow_data_o (iow_data_o),
    .iow_ready_i(iow_ready_i)
);

// File: tb/sout_engine_bench.sv
module sout_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int PW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [PW-1:0] port_i = '0;
    logic          dir_down_i = 1'b0;
    logic          busy_o, done_o;
    logic          mrd_valid_o;
    logic [AW-1:0] mrd_addr_o;
    logic          mrd_ready_i = 1'b0;
    logic          mrsp_valid_i = 1'b0;
    logic [DW-1:0] mrsp_data_i = '0;
    logic          iow_valid_o;
    logic [PW-1:0] iow_port_o;
    logic [DW-1:0] iow_data_o;
    logic          iow_ready_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sout_engine #(.ADDR_W(AW), .CNT_W(CW), .PORT_W(PW), .DATA_W(DW)) u_sout_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .count_i(count_i), .port_i(port_i), .dir_down_i(dir_down_i),
        .busy_o(busy_o), .done_o(done_o),
        .mrd_valid_o(mrd_valid_o), .mrd_addr_o(mrd_addr_o), .mrd_ready_i(mrd_ready_i),
        .mrsp_valid_i(mrsp_valid_i), .mrsp_data_i(mrsp_data_i),
        .iow_valid_o(iow_valid_o), .iow_port_o(iow_port_o), .iow_data_o(iow_data_o),
        .iow_ready_i(iow_ready_i)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // reference model state
    bit            exp_busy = 0, exp_done = 0;
    logic [15:0]   rd_q[$];
    logic [7:0]    wr_q[$];
    logic [15:0]   exp_port = '0;
    int            remaining = 0;
    bit            have_data = 0;
    bit            outstanding = 0;
    int            timer = 0;
    logic [15:0]   pend_addr = '0;
    int unsigned   lcg = 32'h1234_5678;
    int            wr_seen = 0, rd_seen = 0, done_seen = 0;
    string         addr_tag = "R3";
    bit            stall_mode = 0;

    // command mailbox
    bit            cmd_pend = 0;
    logic [15:0]   cmd_addr = '0;
    logic [15:0]   cmd_cnt = '0;
    logic [15:0]   cmd_port = '0;
    bit            cmd_dir = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit nb, nd;
            check(busy_o == exp_busy, "R8", "busy", busy_o, exp_busy);
            check(done_o == exp_done, "R8", "done", done_o, exp_done);
            if (done_o) done_seen++;
            if (iow_valid_o) check(have_data, "R7", "write before data", iow_valid_o, have_data);

            lcg = lcg * 32'd1103515245 + 32'd12345;
            mrd_ready_i = stall_mode ? (lcg[16] | lcg[17]) : 1'b1;
            iow_ready_i = stall_mode ? (lcg[18] | lcg[19]) : 1'b1;
            mrsp_valid_i = 1'b0;
            if (outstanding) begin
                if (timer == 0) begin
                    mrsp_valid_i = 1'b1;
                    mrsp_data_i  = mem_byte(pend_addr);
                    outstanding  = 0;
                    have_data    = 1;
                end else begin
                    timer--;
                end
            end
            start_i = 1'b0;
            if (cmd_pend) begin
                start_i      = 1'b1;
                start_addr_i = cmd_addr;
                count_i      = cmd_cnt;
                port_i       = cmd_port;
                dir_down_i   = cmd_dir;
                cmd_pend     = 0;
            end

            nb = exp_busy;
            nd = 0;
            if (start_i && !exp_busy) begin
                if (count_i == 0) begin
                    nd = 1;
                end else begin
                    nb = 1;
                    remaining = count_i;
                    exp_port  = port_i;
                    for (int i = 0; i < int'(count_i); i++) begin
                        logic [15:0] a;
                        a = dir_down_i ? start_addr_i - 16'(i) : start_addr_i + 16'(i);
                        rd_q.push_back(a);
                        wr_q.push_back(mem_byte(a));
                    end
                end
            end
            if (mrd_valid_o && mrd_ready_i) begin
                check(rd_q.size() > 0, "R5", "extra read", rd_q.size(), 1);
                if (rd_q.size() > 0) begin
                    check(mrd_addr_o == rd_q[0], addr_tag, "read addr", mrd_addr_o, rd_q[0]);
                    void'(rd_q.pop_front());
                end
                rd_seen++;
                outstanding = 1;
                pend_addr   = mrd_addr_o;
                timer       = stall_mode ? int'(lcg[21:20]) : 0;
            end
            if (iow_valid_o && iow_ready_i) begin
                check(iow_port_o == exp_port, "R2", "port", iow_port_o, exp_port);
                check(wr_q.size() > 0, "R5", "extra write", wr_q.size(), 1);
                if (wr_q.size() > 0) begin
                    check(iow_data_o == wr_q[0], "R1", "data", iow_data_o, wr_q[0]);
                    void'(wr_q.pop_front());
                end
                wr_seen++;
                have_data = 0;
                remaining--;
                if (remaining == 0) begin
                    nb = 0;
                    nd = 1;
                end
            end
            exp_busy = nb;
            exp_done = nd;
        end
    end

    task automatic run_cmd(input logic [15:0] a, input logic [15:0] n, input logic [15:0] p,
                           input bit dn, input bit stall, input string tag, input bit intrude);
        @(posedge clk);
        stall_mode = stall;
        addr_tag   = tag;
        wr_seen = 0; rd_seen = 0; done_seen = 0;
        cmd_addr = a; cmd_cnt = n; cmd_port = p; cmd_dir = dn;
        cmd_pend = 1;
        if (intrude) begin
            repeat (10) @(posedge clk);
            check(exp_busy, "R9", "busy before intrusion", exp_busy, 1);
            cmd_addr = a ^ 16'h0F0F; cmd_cnt = 16'd3; cmd_port = ~p; cmd_dir = ~dn;
            cmd_pend = 1;
        end
        do @(posedge clk); while (cmd_pend || exp_busy);
        repeat (3) @(posedge clk);
        check(wr_seen == int'(n), tag, "write count", wr_seen, n);
        check(rd_seen == int'(n), "R5", "read count", rd_seen, n);
        check(done_seen == 1, (n == 0) ? "R6" : "R8", "done pulses", done_seen, 1);
        check(rd_q.size() == 0 && wr_q.size() == 0, "R5", "leftover", rd_q.size() + wr_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o, "R12", "status in reset", {busy_o, done_o}, 0);
        check(!mrd_valid_o && !iow_valid_o, "R12", "valids in reset", {mrd_valid_o, iow_valid_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !mrd_valid_o && !iow_valid_o, "R12", "after reset",
              {busy_o, mrd_valid_o, iow_valid_o}, 0);

        run_cmd(16'h1200, 16'd8,      16'h0047, 0, 0, "R3",  0);
        run_cmd(16'h3456, 16'd7,      16'h0026, 1, 1, "R4",  0);
        run_cmd(16'h4000, 16'd0,      16'h0011, 0, 1, "R6",  0);
        run_cmd(16'h0AB0, 16'd1,      16'h0099, 0, 1, "R5",  0);
        run_cmd(16'h0002, 16'd6,      16'h1000, 1, 1, "R11", 0);
        run_cmd(16'hFFFD, 16'd5,      16'h1001, 0, 0, "R11", 0);
        run_cmd(16'h2200, 16'd12,     16'h0303, 0, 1, "R9",  1);
        run_cmd(16'h8000, 16'h1000,   16'h0047, 0, 1, "R10", 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule